// File: doc/BRIEF.md
# Dual-Branch Glitch-Free Clock Divider

This block produces one output clock from eight free-running source clocks. It holds two complete clock paths, called branch A and branch B. Each branch picks one source through its own selector, divides it by an integer, and can be switched off. A single bit in a 32-bit control word decides which branch feeds the output.

Reprogramming works in two writes. The first write loads new settings into the branch that is not currently selected. The second write flips the branch-pick bit. A handshake in each branch's clock domain then hands the output over: the old branch is gated off on one of its falling edges, and only after that is the new branch gated on, on one of its own falling edges. A status output stays high until the handover has completed and has been seen back in the control clock domain. Software should then allow roughly 25 microseconds for the new clock to settle before it relies on it.

Top module: `twin_path_clkgen`

## Requirements
- R1: A write (`cfg_we` high at a rising edge of `clk_cfg`) loads all 32 bits of `cfg_wdata` into the control word, and `ctl_value` shows the stored word from the next cycle on. The reset value is 0x0000_2000.
- R2: Field layout of the control word:
  - Branch A: enable at bit 13, source index at bits 12:10, divider at bits 9:0.
  - Branch B: the same fields shifted up by 16, so enable at bit 29, source index at bits 28:26, divider at bits 25:16.
  - Bit 15 picks the output branch: 0 picks A, 1 picks B.
- R3: A divider value N makes the branch clock period (N+1) times the source period. N = 0 passes the source through, and N = 1023 is the largest value.
- R4: Source index k selects `src_clk[k]`. Index 0 is the crystal oscillator and index 7 is the slow real-time clock.
- R5: After bit 15 is flipped, `clk_out` carries the newly picked branch's clock. The two branches are never gated onto the output at the same time.
- R6: `switching` rises in the cycle after a write that changes bit 15 while the block is settled. It stays high until the new branch is gated on and the old one is gated off, and it is low in steady state.
- R7: A branch whose enable bit is 0 drives a constant low. Its divider counter is held at zero. If such a branch is picked, `clk_out` stays low and `switching` stays high until the branch is enabled.
- R8: Changing the divider of the currently picked branch causes no switch (`switching` stays low). The new ratio is applied at that branch's next divided-clock boundary.
- R9: While reset is active, `clk_out` is low and `switching` is high. After reset, branch A passes `src_clk[0]` through to `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Control register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to store |
| src_clk | input | 8 | Source clocks; index 0 is the crystal, index 7 is the real-time clock |
| clk_out | output | 1 | Glitch-free output clock |
| switching | output | 1 | High while a branch handover is in progress |
| ctl_value | output | 32 | Stored control word |

## Verification
The assertions rely on four assumptions about how the block is driven:
- The sources toggle continuously.
- Bit 15 is flipped only while `switching` is low.
- The source index of the branch currently feeding the output is never changed.
- Only a branch that is idle, or that is being re-enabled, is given a new source.

Under these assumptions the branch enables are mutually exclusive, and a flip always raises the status. The stimulus respects all four. Before every flip it waits for the status to fall. It loads new source indexes only into the idle branch, and it changes only the divider of the picked branch. It also samples the output clock period only after several edges of the new branch have passed.

// File: rtl/twin_path_clkgen.sv
`timescale 1ns/1ps
module twin_path_clkgen #(
  parameter int          N_SRC   = 8,
  parameter int          DIV_W   = 10,
  parameter logic [31:0] RST_CTL = 32'h0000_2000
) (
  input  logic              clk_cfg,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic [N_SRC-1:0]  src_clk,
  output logic              clk_out,
  output logic              switching,
  output logic [31:0]       ctl_value
);
  localparam int SEL_W    = $clog2(N_SRC);
  localparam int HALF     = 16;
  localparam int SEL_LSB  = DIV_W;
  localparam int EN_BIT   = DIV_W + SEL_W;
  localparam int PICK_BIT = 15;

  logic [31:0] ctl_q;
  logic [1:0]  br_clk;
  logic [1:0]  br_on;
  logic [1:0]  seen1, seen2;
  logic        settled;
  logic        unused_bits;

  always_ff @(posedge clk_cfg or negedge rst_n)
    if (!rst_n)      ctl_q <= RST_CTL;
    else if (cfg_we) ctl_q <= cfg_wdata;

  assign ctl_value   = ctl_q;
  assign unused_bits = ^{ctl_q[31:HALF+EN_BIT+1], ctl_q[PICK_BIT-1:EN_BIT+1]};

  for (genvar b = 0; b < 2; b++) begin : g_br
    localparam int OFS = b * HALF;

    logic             f_en;
    logic [SEL_W-1:0] f_sel;
    logic [DIV_W-1:0] f_div;
    logic             en_w;
    logic [SEL_W-1:0] sel_w;
    logic [DIV_W-1:0] div_w;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   cnt_nx;
    logic [DIV_W:0]   hi_len;
    logic             dq;
    logic             mclk;
    logic             load;
    logic             want;
    logic [1:0]       hs;
    logic             on_q;

    assign f_en   = ctl_q[OFS+EN_BIT];
    assign f_sel  = ctl_q[OFS+SEL_LSB +: SEL_W];
    assign f_div  = ctl_q[OFS +: DIV_W];
    assign mclk   = src_clk[sel_w];
    assign load   = !en_w || (cnt == div_w);
    assign cnt_nx = {1'b0, cnt} + (DIV_W+1)'(1);
    assign hi_len = ({1'b0, div_w} + (DIV_W+1)'(2)) >> 1;

    always_ff @(posedge mclk or negedge rst_n)
      if (!rst_n) begin
        en_w  <= 1'b0;
        sel_w <= '0;
        div_w <= '0;
        cnt   <= '0;
        dq    <= 1'b0;
      end else if (load) begin
        en_w  <= f_en;
        sel_w <= f_sel;
        div_w <= f_div;
        cnt   <= '0;
        dq    <= f_en && (f_div != '0);
      end else begin
        cnt   <= cnt_nx[DIV_W-1:0];
        dq    <= cnt_nx < hi_len;
      end

    assign br_clk[b] = (div_w == '0) ? (mclk & en_w) : dq;
    assign want      = (ctl_q[PICK_BIT] == 1'(b));

    always_ff @(posedge br_clk[b] or negedge rst_n)
      if (!rst_n) hs <= '0;
      else        hs <= {hs[0], want & ~br_on[1-b]};

    always_ff @(negedge br_clk[b] or negedge rst_n)
      if (!rst_n) on_q <= 1'b0;
      else        on_q <= hs[1];

    assign br_on[b] = on_q;

    AST_CNT_RANGE: assert property (@(posedge mclk) disable iff (!rst_n)
      cnt <= div_w);                                            // R3
    AST_OFF_LOW: assert property (@(posedge mclk) disable iff (!rst_n)
      !en_w |-> (!dq && cnt == '0));                            // R7
  end

  assign clk_out = (br_clk[0] & br_on[0]) | (br_clk[1] & br_on[1]);

  always_ff @(posedge clk_cfg or negedge rst_n)
    if (!rst_n) begin
      seen1 <= '0;
      seen2 <= '0;
    end else begin
      seen1 <= br_on;
      seen2 <= seen1;
    end

  assign settled   = ctl_q[PICK_BIT] ? (seen2 == 2'b10) : (seen2 == 2'b01);
  assign switching = !settled;

  AST_ONE_BRANCH: assert property (@(posedge clk_cfg) disable iff (!rst_n)
    !(br_on[0] && br_on[1]));                                   // R5
  AST_WRITE_LOAD: assert property (@(posedge clk_cfg) disable iff (!rst_n)
    cfg_we |=> (ctl_value == $past(cfg_wdata)));                // R1
  AST_BUSY_ON_FLIP: assert property (@(posedge clk_cfg) disable iff (!rst_n)
    (cfg_we && !switching && (cfg_wdata[PICK_BIT] != ctl_q[PICK_BIT])) |=> switching); // R6
endmodule

// File: tb/test_twin_path_clkgen.sv
`timescale 1ns/1ps
module test_twin_path_clkgen;
  localparam real CLK_PERIOD = 10.0;
  localparam int  NV = 6;
  localparam int  V_SRC [NV] = '{1, 0, 7, 4, 2, 5};
  localparam int  V_DIV [NV] = '{0, 3, 1, 9, 2, 0};
  localparam int  V_PER [NV] = '{8, 24, 40, 140, 30, 16};

  logic        clk_cfg = 1'b0;
  logic        rst_n   = 1'b0;
  logic        cfg_we  = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  src_clk;
  logic        clk_out, switching;
  logic [31:0] ctl_value;
  int          checks = 0;
  int          fails  = 0;

  twin_path_clkgen i_twin_path_clkgen (
    .clk_cfg(clk_cfg), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_clk(src_clk), .clk_out(clk_out), .switching(switching), .ctl_value(ctl_value)
  );

  initial forever #(CLK_PERIOD/2) clk_cfg = ~clk_cfg;

  for (genvar i = 0; i < 8; i++) begin : g_src
    logic t = 1'b0;
    initial forever #(3 + i) t = ~t;
    assign src_clk[i] = t;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input bit en, input int sel, input int dv, input int b);
    logic [31:0] w = '0;
    w[16*b + 13]      = en;
    w[16*b + 10 +: 3] = sel[2:0];
    w[16*b +: 10]     = dv[9:0];
    return w;
  endfunction

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk_cfg);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk_cfg);
    cfg_we = 1'b0;
  endtask

  task automatic wait_settle(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk_cfg);
      if (!switching) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(output int per);
    realtime t0;
    repeat (3) @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    per = $rtoi($realtime - t0 + 0.5);
  endtask

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] cur_word, w;
    int cur, idl, per, highs;
    bit ok;

    repeat (3) @(negedge clk_cfg);
    chk(ctl_value == 32'h0000_2000, "R1", "reset word", ctl_value, 32'h2000);
    chk(switching == 1'b1, "R9", "switching in reset", switching, 1);
    highs = 0;
    for (int k = 0; k < 50; k++) begin #1; if (clk_out) highs++; end
    chk(highs == 0, "R9", "clk_out high samples in reset", highs, 0);

    rst_n = 1'b1;
    wait_settle(ok);
    chk(ok, "R9", "settle after reset", ok, 1);
    measure(per);
    chk(per == 6, "R9", "default period src0", per, 6);

    cur_word = 32'h0000_2000;
    cur = 0;
    for (int v = 0; v < NV; v++) begin
      idl = 1 - cur;
      w = (cur_word & (32'h3FFF << (16*cur))) | fld(1'b1, V_SRC[v], V_DIV[v], idl);
      w[15] = cur[0];
      cfg_write(w);
      chk(ctl_value == w, "R1", "word readback", ctl_value, w);
      chk(switching == 1'b0, "R2", "idle branch write no switch", switching, 0);
      w[15] = idl[0];
      cfg_write(w);
      chk(switching == 1'b1, "R6", "busy after flip", switching, 1);
      wait_settle(ok);
      chk(ok, "R5", "handover completes", ok, 1);
      measure(per);
      chk(per == V_PER[v], "R3", "divided period", per, V_PER[v]);
      cur = idl;
      cur_word = w;
    end

    // R8: reprogram the active branch A (src 5) to divider 4
    w = cur_word;
    w[9:0] = 10'd4;
    cfg_write(w);
    chk(switching == 1'b0, "R8", "active rewrite no switch", switching, 0);
    measure(per);
    chk(per == 80, "R8", "active branch new period", per, 80);
    cur_word = w;

    // R7: pick a disabled branch B
    w = (cur_word & 32'h0000_3FFF) | fld(1'b0, 0, 0, 1);
    w[15] = 1'b1;
    cfg_write(w);
    repeat (100) @(negedge clk_cfg);
    highs = 0;
    for (int k = 0; k < 1000; k++) begin #1; if (clk_out) highs++; end
    chk(highs == 0, "R7", "clk_out high samples on disabled branch", highs, 0);
    chk(switching == 1'b1, "R7", "switching stuck on disabled branch", switching, 1);
    w = (cur_word & 32'h0000_3FFF) | fld(1'b1, 3, 0, 1);
    w[15] = 1'b1;
    cfg_write(w);
    wait_settle(ok);
    chk(ok, "R7", "settle after enable", ok, 1);
    measure(per);
    chk(per == 12, "R4", "src3 passthrough period", per, 12);
    cur_word = w;

    // R3: largest divider on branch A, source 0
    w = (cur_word & 32'h3FFF_0000) | fld(1'b1, 0, 1023, 0);
    w[15] = 1'b1;
    cfg_write(w);
    w[15] = 1'b0;
    cfg_write(w);
    wait_settle(ok);
    chk(ok, "R5", "settle to max divider", ok, 1);
    measure(per);
    chk(per == 6144, "R3", "max divider period", per, 6144);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule